// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides, cycle by cycle, which of four power states a processor occupies: running, sleep (CPU clock halted, peripherals still clocked), software standby (every clock and the oscillator off, peripherals held in reset) and hardware standby (forced off by a dedicated pin). The CPU enters sleep or software standby with a one-cycle sleep strobe. A select bit chooses between the two. The controller drives clock-run enables, a peripheral reset, an oscillator enable, and one-cycle strobes that tell the CPU to begin interrupt handling or reset handling.

The two wake paths from software standby differ. An interrupt wake first restarts the oscillator. It then waits out a settling count chosen by a 3-bit code, and only after that restores the clocks and requests interrupt handling. A reset wake turns the clocks on in the next cycle. It holds the reset state until the reset input returns high, then requests reset handling. The controller runs on a free-running reference clock. The settling lengths are parameters: `BASE_LOG2` sets the length for code 0, and `SHORT_LOG2` sets the length for code 6.

Top module: `lpm_seq`

## Requirements
- R1: While `res_n` is low and `stby_n` is high, the outputs show the reset state: `mode`=0, both clock enables 1, `osc_en`=1, `per_rst`=1. In the first cycle after `res_n` is seen high, the state is running (`per_rst`=0) and `rst_start` is 1.
- R2: A `sleep_req` strobe while running, with `ssby_sel`=0, enters sleep in the next cycle: `mode`=1, `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, `per_rst`=0.
- R3: In sleep, an unmasked `nmi` (`nmi_mask`=0), or any `irq[i]` with `irq_en[i]`=1 while `irq_mask`=0, returns the block to running in the next cycle with `irq_start`=1.
- R4: In sleep, interrupt lines that are disabled or masked leave the outputs unchanged.
- R5: A `sleep_req` strobe while running, with `ssby_sel`=1, enters software standby: `mode`=2, both clock enables 0, `osc_en`=0, `per_rst`=1.
- R6: In software standby, only `nmi` and `irq[NWAKE-1:0]` (bit 0 upward), subject to the same enable and mask rules as R3, cause a wake. Higher irq lines do not, and a standby that does not wake leaves the outputs unchanged.
- R7: An interrupt wake from software standby sets `osc_en`=1 at once, with `mode`=2 and clocks still off, for exactly L cycles. `settle_sel` is sampled at the wake. L is 2^(BASE_LOG2+c) for codes c=0..5, 2^SHORT_LOG2 for code 6 and 2^(SHORT_LOG2+1) for code 7. Running then resumes with `irq_start`=1.
- R8: `res_n` low in software standby or during settling moves the block to the reset state in the next cycle, abandoning any settling count. Reset wins over a wake interrupt seen in the same cycle.
- R9: `res_n` low in sleep moves the block to the reset state in the next cycle.
- R10: `stby_n` low, from any state and even with `res_n` low, gives hardware standby in the next cycle: `mode`=3, clocks and oscillator off, `per_rst`=1.
- R11: When `stby_n` returns high, the block passes through the reset state and raises `rst_start` once `res_n` is high.
- R12: `irq_start` and `rst_start` are each high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| res_n | input | 1 | Active-low reset request |
| stby_n | input | 1 | Active-low hardware standby request |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| ssby_sel | input | 1 | 1 selects software standby, 0 selects sleep |
| settle_sel | input | 3 | Oscillator settling-length code |
| nmi | input | 1 | Non-maskable interrupt request |
| nmi_mask | input | 1 | CPU mask for nmi |
| irq | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line source enables |
| irq_mask | input | 1 | CPU mask for all irq lines |
| cpu_clk_en | output | 1 | CPU clock run enable |
| per_clk_en | output | 1 | Peripheral clock run enable |
| per_rst | output | 1 | Peripheral reset |
| osc_en | output | 1 | Oscillator enable |
| irq_start | output | 1 | Start interrupt handling strobe |
| rst_start | output | 1 | Start reset handling strobe |
| mode | output | 2 | 0 running/reset, 1 sleep, 2 software standby, 3 hardware standby |

## Verification
Every output comes from a single state register, so every result is due one edge after the input that causes it. The exception is the settling exit, which is due exactly L edges after the wake edge. The bench changes inputs 2 ns after a rising edge and samples the outputs just before it changes inputs again. It checks the settling window on every one of its L cycles, so an early or late exit is caught in the exact cycle it happens. Randomized wake patterns are scored by a bench function that applies the enable, mask and wake-line rules, and directed cases cover the reset, standby and collision priorities.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int NIRQ       = 6,
  parameter int NWAKE      = 3,
  parameter int BASE_LOG2  = 13,
  parameter int SHORT_LOG2 = 10
) (
  input  logic            clk,
  input  logic            res_n,
  input  logic            stby_n,
  input  logic            sleep_req,
  input  logic            ssby_sel,
  input  logic [2:0]      settle_sel,
  input  logic            nmi,
  input  logic            nmi_mask,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            irq_mask,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            per_rst,
  output logic            osc_en,
  output logic            irq_start,
  output logic            rst_start,
  output logic [1:0]      mode
);

  localparam int CW = BASE_LOG2 + 6;
  localparam logic [NIRQ-1:0] SB_LINES = NIRQ'((64'd1 << NWAKE) - 64'd1);

  typedef enum logic [2:0] {S_ACT, S_SLP, S_SSB, S_SET, S_RST, S_HWS} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           wake_slp, wake_sb;

  function automatic logic [CW-1:0] settle_len(input logic [2:0] code);
    if (code < 3'd6) settle_len = CW'(64'd1 << (BASE_LOG2 + int'(code)));
    else             settle_len = CW'(64'd1 << (SHORT_LOG2 + int'(code) - 6));
  endfunction

  assign wake_slp = (nmi & ~nmi_mask) | ((|(irq & irq_en)) & ~irq_mask);
  assign wake_sb  = (nmi & ~nmi_mask) | ((|(irq & irq_en & SB_LINES)) & ~irq_mask);

  always_ff @(posedge clk) begin
    irq_start <= 1'b0;
    rst_start <= 1'b0;
    if (!stby_n)           st <= S_HWS;
    else if (st == S_HWS)  st <= S_RST;
    else if (!res_n)       st <= S_RST;
    else begin
      case (st)
        S_RST: begin
          st        <= S_ACT;
          rst_start <= 1'b1;
        end
        S_ACT: if (sleep_req) st <= ssby_sel ? S_SSB : S_SLP;
        S_SLP: if (wake_slp) begin
          st        <= S_ACT;
          irq_start <= 1'b1;
        end
        S_SSB: if (wake_sb) begin
          st  <= S_SET;
          cnt <= settle_len(settle_sel) - CW'(1);
        end
        S_SET: begin
          if (cnt == '0) begin
            st        <= S_ACT;
            irq_start <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= S_RST;
      endcase
    end
  end

  assign cpu_clk_en = (st == S_ACT) || (st == S_RST);
  assign per_clk_en = (st == S_ACT) || (st == S_RST) || (st == S_SLP);
  assign per_rst    = (st == S_SSB) || (st == S_SET) || (st == S_HWS) || (st == S_RST);
  assign osc_en     = (st != S_SSB) && (st != S_HWS);
  assign mode       = (st == S_SLP) ? 2'd1 :
                      (st == S_SSB || st == S_SET) ? 2'd2 :
                      (st == S_HWS) ? 2'd3 : 2'd0;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       res_n,
  input logic       stby_n,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       per_rst,
  input logic       osc_en,
  input logic       irq_start,
  input logic       rst_start,
  input logic [1:0] mode
);

  a_r12_irq_pulse: assert property (@(posedge clk) disable iff (!res_n)
    irq_start |=> !irq_start);

  a_r12_rst_pulse: assert property (@(posedge clk) disable iff (!res_n)
    rst_start |=> !rst_start);

  a_r10_hw_standby: assert property (@(posedge clk) disable iff (!res_n)
    !stby_n |=> (mode == 2'd3) && !osc_en && !cpu_clk_en && !per_clk_en && per_rst);

  a_r5_standby_quiet: assert property (@(posedge clk) disable iff (!res_n)
    (mode == 2'd2) |-> !cpu_clk_en && !per_clk_en && per_rst);

  a_r2_sleep_clocks: assert property (@(posedge clk) disable iff (!res_n)
    (mode == 2'd1) |-> !cpu_clk_en && per_clk_en && osc_en && !per_rst);

  a_r3_irq_running: assert property (@(posedge clk) disable iff (!res_n)
    irq_start |-> (mode == 2'd0) && cpu_clk_en && !per_rst);

  a_r7_settle_exit: assert property (@(posedge clk) disable iff (!res_n)
    (irq_start && $past(mode) == 2'd2) |-> $past(osc_en));

endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .res_n(res_n), .stby_n(stby_n), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .per_rst(per_rst), .osc_en(osc_en),
  .irq_start(irq_start), .rst_start(rst_start), .mode(mode)
);

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 6, NWAKE = 3, BL = 4, SL = 2;

  localparam logic [7:0] V_ACT = 8'b00_1101_00;
  localparam logic [7:0] V_RST = 8'b00_1111_00;
  localparam logic [7:0] V_SLP = 8'b01_0101_00;
  localparam logic [7:0] V_SSB = 8'b10_0010_00;
  localparam logic [7:0] V_SET = 8'b10_0011_00;
  localparam logic [7:0] V_HWS = 8'b11_0010_00;

  logic clk = 0, res_n = 0, stby_n = 1, sleep_req = 0, ssby_sel = 0;
  logic [2:0] settle_sel = 0;
  logic nmi = 0, nmi_mask = 0, irq_mask = 0;
  logic [NIRQ-1:0] irq = '0, irq_en = '0;
  logic cpu_clk_en, per_clk_en, per_rst, osc_en, irq_start, rst_start;
  logic [1:0] mode;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_seq #(.NIRQ(NIRQ), .NWAKE(NWAKE), .BASE_LOG2(BL), .SHORT_LOG2(SL)) u_lpm_seq (
    .clk(clk), .res_n(res_n), .stby_n(stby_n), .sleep_req(sleep_req),
    .ssby_sel(ssby_sel), .settle_sel(settle_sel), .nmi(nmi), .nmi_mask(nmi_mask),
    .irq(irq), .irq_en(irq_en), .irq_mask(irq_mask), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .per_rst(per_rst), .osc_en(osc_en),
    .irq_start(irq_start), .rst_start(rst_start), .mode(mode));

  function automatic int settle_len(input int c);
    return (c < 6) ? (1 << (BL + c)) : (1 << (SL + c - 6));
  endfunction

  function automatic bit wake_exp(input bit sb, input bit n, input bit nm,
                                  input logic [NIRQ-1:0] r, input logic [NIRQ-1:0] e, input bit m);
    logic [NIRQ-1:0] hit = r & e;
    if (sb) hit = hit & NIRQ'((1 << NWAKE) - 1);
    return (n && !nm) || ((|hit) && !m);
  endfunction

  task automatic tick();
    @(posedge clk); #2;
    cyc++;
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] act = {mode, cpu_clk_en, per_clk_en, per_rst, osc_en, irq_start, rst_start};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic enter(input bit sb, input logic [2:0] code);
    ssby_sel = sb; settle_sel = code; sleep_req = 1;
    tick();
    sleep_req = 0;
    chk(sb ? "R5 enter standby" : "R2 enter sleep", sb ? V_SSB : V_SLP);
  endtask

  task automatic settle_out(input int c);
    int len = settle_len(c);
    chk("R7 settle first", V_SET);
    for (int k = 1; k < len; k++) begin
      tick();
      chk("R7 settle window", V_SET);
    end
    tick();
    chk("R7 settle exit", V_ACT | 8'd2);
    tick();
    chk("R12 irq strobe width", V_ACT);
  endtask

  initial begin
    void'($urandom(32'd5150));
    tick(); tick();
    chk("R1 reset state", V_RST);
    res_n = 1; tick();
    chk("R1 reset release", V_ACT | 8'd1);
    tick();
    chk("R12 rst strobe width", V_ACT);

    enter(0, 0);
    irq = 6'b100000; irq_en = 6'b011111; tick();
    chk("R4 disabled line", V_SLP);
    irq_en = 6'b111111; irq_mask = 1; nmi = 1; nmi_mask = 1; tick();
    chk("R4 masked lines", V_SLP);
    irq_mask = 0; tick(); irq = '0; nmi = 0; nmi_mask = 0;
    chk("R3 sleep wake", V_ACT | 8'd2);
    tick();
    chk("R12 irq strobe width", V_ACT);

    enter(0, 0);
    res_n = 0; tick();
    chk("R9 reset in sleep", V_RST);
    res_n = 1; tick();
    chk("R9 reset release", V_ACT | 8'd1);

    enter(1, 3'd6);
    irq = 6'b111000; irq_en = '1; tick();
    chk("R6 non-wake lines", V_SSB);
    irq = 6'b000100; tick(); irq = '0;
    settle_out(6);

    enter(1, 3'd1);
    nmi = 1; tick(); nmi = 0;
    for (int k = 0; k < 5; k++) tick();
    chk("R7 mid settle", V_SET);
    res_n = 0; tick();
    chk("R8 reset abandons settle", V_RST);
    res_n = 1; tick();
    chk("R8 reset release", V_ACT | 8'd1);

    enter(1, 3'd0);
    nmi = 1; res_n = 0; tick(); nmi = 0;
    chk("R8 reset beats wake", V_RST);
    tick();
    chk("R8 clocks during reset", V_RST);
    res_n = 1; tick();
    chk("R8 reset release", V_ACT | 8'd1);

    stby_n = 0; res_n = 0; tick();
    chk("R10 hw standby over reset", V_HWS);
    stby_n = 1; tick();
    chk("R11 leave hw standby", V_RST);
    tick();
    chk("R11 hold reset", V_RST);
    res_n = 1; tick();
    chk("R11 reset handling", V_ACT | 8'd1);

    enter(1, 3'd7);
    stby_n = 0; tick();
    chk("R10 hw standby from sw standby", V_HWS);
    stby_n = 1; tick();
    chk("R11 through reset", V_RST);
    tick();
    chk("R11 reset handling", V_ACT | 8'd1);

    for (int i = 0; i < 120; i++) begin
      bit sb = 1'($urandom);
      int c = int'($urandom % 8);
      bit w;
      enter(sb, 3'(c));
      nmi = 1'($urandom); nmi_mask = ($urandom % 3) != 0;
      irq = NIRQ'($urandom); irq_en = NIRQ'($urandom); irq_mask = ($urandom % 4) == 0;
      w = wake_exp(sb, nmi, nmi_mask, irq, irq_en, irq_mask);
      tick();
      nmi = 0; nmi_mask = 0; irq = '0; irq_mask = 0;
      if (!w) begin
        chk(sb ? "R6 random no wake" : "R4 random no wake", sb ? V_SSB : V_SLP);
        nmi = 1; tick(); nmi = 0;
      end
      if (sb) settle_out(c);
      else begin
        chk("R3 random wake", V_ACT | 8'd2);
        tick();
        chk("R12 irq strobe width", V_ACT);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule